// File: doc/BRIEF.md
# Masked Layer Coincidence Trigger

This block builds a final trigger from the per-layer trigger pulses of a stacked detector. Each layer delivers its own already-qualified fold signal. The block synchronizes those signals and reduces each rising edge to a single hit. It collects the hits inside a short programmable coincidence window, removes masked layers, and fires when the number of distinct layers hit reaches a programmable threshold. Several fixed thresholds are evaluated on every window in parallel, and each one has its own saturating rate scaler.

A fired coincidence sets a sticky attention flag toward the host. While that flag is set, the gated trigger output stays quiet and the captured hit pattern is frozen. The pattern is the raw layers, including masked ones, together with the per-threshold flags. The host reads this snapshot, then clears the flag through a command write. The host reaches every setting, scaler and snapshot through a small address/data register port with a one-cycle registered read.

Top module: `layer_coinc_trigger`

## Requirements
- R1: Each layer input passes through a two-stage synchronizer, and only its rising edge counts as a hit. A level held high for many cycles contributes to exactly one window.
- R2: The first hit when no window is open starts a window of W = CFG[10:8]+1 clock samples, and hits during those samples are OR-ed together. A hit that arrives on the closing cycle starts a new window.
- R3: The trigger output pulses for one cycle when the number of unmasked layers in a window is at least the threshold n = CFG[3:0]. It rises 2+W clocks after the first clock edge that sees the input, and a window with n-1 layers produces no pulse.
- R4: A written threshold of 0 is stored as 1, and a value above the layer count (12) is stored as 12. CFG reads back the stored value.
- R5: Register MASK (address 0) bit i set to 1 removes layer i from every count.
- R6: A fired coincidence sets the attention output and STAT bit 0 (address 3). Only a write to CMD (address 2) with bit 0 set clears it, and a write with bit 0 clear leaves it set.
- R7: While attention is set, a fired coincidence produces no trigger output pulse and does not advance the trigger-output scaler.
- R8: On a non-vetoed trigger, CAP (address 4) captures the raw window pattern, masked layers included, in bits [11:0]. It captures the flags of the preset thresholds in bits [19:16]. CAP is unchanged while attention is set.
- R9: Each preset scaler (address 8+i) counts the windows whose unmasked count reaches preset threshold i (defaults 1, 2, 4, 8), whether or not the trigger is vetoed. Its width is PRESET_SCALER_W, 16 by default.
- R10: The trigger-output scaler (address 5, TRIG_SCALER_W bits, 24 by default) counts the trigger output pulses.
- R11: Every scaler stops at its maximum value instead of wrapping. A write to CMD with bit 1 set clears all of them.
- R12: After reset, MASK is 0, CFG reads 0x00000002 (n=2, W=1), attention and the trigger output are low, and all scalers and CAP are zero.
- R13: A read strobe presents the addressed register on the read data port one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layer_in | input | NUM_LAYERS | Asynchronous per-layer fold trigger signals |
| host_addr | input | 4 | Register address |
| host_we | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 32 | Registered read data |
| trig_out | output | 1 | Gated final trigger pulse |
| host_attn | output | 1 | Sticky attention request |

## Verification
The coincidence function is driven with simultaneous multi-layer pulses at the threshold and one layer below it. These patterns separate a correct `>=` compare from an off-by-one compare. Staggered pulses at spacings of W-1 and W check that the window edges are placed exactly, and a long held level shows that edge detection stops a level from being counted again. Patterns that mix masked and unmasked layers show that the mask acts on the count but not on the captured raw pattern. A coincidence fired while attention is pending shows that the veto, the capture freeze and the preset counting behave independently.

// File: rtl/coinc_pkg.sv
package coinc_pkg;
  localparam int HOST_AW = 4;
  localparam int HOST_DW = 32;

  localparam logic [HOST_AW-1:0] ADR_MASK    = 4'd0;
  localparam logic [HOST_AW-1:0] ADR_CFG     = 4'd1;
  localparam logic [HOST_AW-1:0] ADR_CMD     = 4'd2;
  localparam logic [HOST_AW-1:0] ADR_STAT    = 4'd3;
  localparam logic [HOST_AW-1:0] ADR_CAP     = 4'd4;
  localparam logic [HOST_AW-1:0] ADR_TRIGCNT = 4'd5;
  localparam logic [HOST_AW-1:0] ADR_PRESET0 = 4'd8;

  localparam int CMD_BIT_ATTN = 0;
  localparam int CMD_BIT_SCAL = 1;
  localparam int CFG_WIN_LSB  = 8;
  localparam int CAP_FLAG_LSB = 16;
endpackage

// File: rtl/layer_edge_detect.sv
module layer_edge_detect #(
  parameter int LANES = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lvl_in,
  output logic [LANES-1:0] rise_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= lvl_in[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign rise_out[g] = sync_q & ~prev_q;
  end

  // R1
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    (rise_out & $past(rise_out)) == '0);
endmodule

// File: rtl/coinc_window.sv
module coinc_window #(
  parameter int LANES = 12,
  parameter int WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] hit_in,
  input  logic [WIN_W-1:0] len_m1,
  output logic             grp_done,
  output logic [LANES-1:0] grp_pattern
);
  logic             open_q;
  logic [WIN_W-1:0] left_q;
  logic [LANES-1:0] acc_q;
  logic             idle_or_last;

  assign idle_or_last = !open_q || (left_q == '0);
  assign grp_done     = open_q && (left_q == '0);
  assign grp_pattern  = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      left_q <= '0;
      acc_q  <= '0;
    end else if (idle_or_last) begin
      if (|hit_in) begin
        open_q <= 1'b1;
        left_q <= len_m1;
        acc_q  <= hit_in;
      end else begin
        open_q <= 1'b0;
      end
    end else begin
      acc_q  <= acc_q | hit_in;
      left_q <= left_q - 1'b1;
    end
  end

  // R2
  close_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (grp_done && hit_in == '0) |=> !open_q);

  // R2
  open_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!open_q && hit_in != '0) |=> (open_q && acc_q == $past(hit_in)));
endmodule

// File: rtl/coinc_compare.sv
module coinc_compare #(
  parameter int LANES   = 12,
  parameter int PRESETS = 4,
  parameter int CNT_W   = 4,
  parameter logic [PRESETS*CNT_W-1:0] PRESET_N = '0
) (
  input  logic [LANES-1:0]   pattern,
  input  logic [LANES-1:0]   mask,
  input  logic [CNT_W-1:0]   thr,
  output logic               main_hit,
  output logic [PRESETS-1:0] preset_hit
);
  logic [LANES-1:0] live;
  logic [CNT_W-1:0] cnt;

  assign live = pattern & ~mask;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LANES; i++) cnt = cnt + CNT_W'(live[i]);
  end

  assign main_hit = (cnt >= thr);

  for (genvar p = 0; p < PRESETS; p++) begin : g_preset
    assign preset_hit[p] = (cnt >= PRESET_N[p*CNT_W +: CNT_W]);
  end
endmodule

// File: rtl/rate_scaler.sv
module rate_scaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                  count <= '0;
    else if (inc && count != TOP)    count <= count + 1'b1;
  end

  // R11
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (count == TOP && !clr) |=> count == TOP);

  // R11
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);
endmodule

// File: rtl/layer_coinc_trigger.sv
module layer_coinc_trigger
  import coinc_pkg::*;
#(
  parameter int NUM_LAYERS      = 12,
  parameter int WIN_MAX         = 8,
  parameter int NUM_PRESETS     = 4,
  parameter logic [NUM_PRESETS*$clog2(NUM_LAYERS+1)-1:0] PRESET_N = 16'h8421,
  parameter int PRESET_SCALER_W = 16,
  parameter int TRIG_SCALER_W   = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LAYERS-1:0] layer_in,
  input  logic [3:0]            host_addr,
  input  logic                  host_we,
  input  logic [31:0]           host_wdata,
  input  logic                  host_rd,
  output logic [31:0]           host_rdata,
  output logic                  trig_out,
  output logic                  host_attn
);
  localparam int CNT_W = $clog2(NUM_LAYERS + 1);
  localparam int WIN_W = $clog2(WIN_MAX);

  logic [NUM_LAYERS-1:0]  rise;
  logic                   grp_done;
  logic [NUM_LAYERS-1:0]  grp_pattern;
  logic                   main_hit;
  logic [NUM_PRESETS-1:0] preset_hit;

  logic [NUM_LAYERS-1:0]  mask_q;
  logic [CNT_W-1:0]       thr_q;
  logic [WIN_W-1:0]       winm1_q;
  logic                   attn_q;
  logic                   trig_q;
  logic [NUM_LAYERS-1:0]  cap_raw_q;
  logic [NUM_PRESETS-1:0] cap_flag_q;
  logic [HOST_DW-1:0]     rdata_q;
  logic [HOST_DW-1:0]     rd_mux;

  logic fire, pass, cmd_wr, clr_attn, clr_scal;
  logic [TRIG_SCALER_W-1:0]   trig_cnt;
  logic [PRESET_SCALER_W-1:0] preset_cnt [NUM_PRESETS];

  logic unused_wbits;
  assign unused_wbits = ^host_wdata[HOST_DW-1:CFG_WIN_LSB+WIN_W];

  function automatic logic [CNT_W-1:0] clamp_thr(input logic [CNT_W-1:0] v);
    if (v == '0)                          return CNT_W'(1);
    else if (v > CNT_W'(NUM_LAYERS))      return CNT_W'(NUM_LAYERS);
    else                                  return v;
  endfunction

  layer_edge_detect #(.LANES(NUM_LAYERS)) u_edge (
    .clk(clk), .rst(rst), .lvl_in(layer_in), .rise_out(rise)
  );

  coinc_window #(.LANES(NUM_LAYERS), .WIN_W(WIN_W)) u_win (
    .clk(clk), .rst(rst), .hit_in(rise), .len_m1(winm1_q),
    .grp_done(grp_done), .grp_pattern(grp_pattern)
  );

  coinc_compare #(
    .LANES(NUM_LAYERS), .PRESETS(NUM_PRESETS), .CNT_W(CNT_W), .PRESET_N(PRESET_N)
  ) u_cmp (
    .pattern(grp_pattern), .mask(mask_q), .thr(thr_q),
    .main_hit(main_hit), .preset_hit(preset_hit)
  );

  assign fire     = grp_done && main_hit;
  assign pass     = fire && !attn_q;
  assign cmd_wr   = host_we && (host_addr == ADR_CMD);
  assign clr_attn = cmd_wr && host_wdata[CMD_BIT_ATTN];
  assign clr_scal = cmd_wr && host_wdata[CMD_BIT_SCAL];

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      thr_q   <= CNT_W'(2);
      winm1_q <= '0;
    end else if (host_we) begin
      if (host_addr == ADR_MASK) mask_q <= host_wdata[NUM_LAYERS-1:0];
      if (host_addr == ADR_CFG) begin
        thr_q   <= clamp_thr(host_wdata[CNT_W-1:0]);
        winm1_q <= host_wdata[CFG_WIN_LSB +: WIN_W];
      end
    end
  end

  // trigger, attention and capture
  always_ff @(posedge clk) begin
    if (rst) begin
      attn_q     <= 1'b0;
      trig_q     <= 1'b0;
      cap_raw_q  <= '0;
      cap_flag_q <= '0;
    end else begin
      trig_q <= pass;
      if (fire)          attn_q <= 1'b1;
      else if (clr_attn) attn_q <= 1'b0;
      if (pass) begin
        cap_raw_q  <= grp_pattern;
        cap_flag_q <= preset_hit;
      end
    end
  end

  rate_scaler #(.W(TRIG_SCALER_W)) u_trig_scaler (
    .clk(clk), .rst(rst), .clr(clr_scal), .inc(pass), .count(trig_cnt)
  );

  for (genvar p = 0; p < NUM_PRESETS; p++) begin : g_scal
    rate_scaler #(.W(PRESET_SCALER_W)) u_scaler (
      .clk(clk), .rst(rst), .clr(clr_scal),
      .inc(grp_done && preset_hit[p]), .count(preset_cnt[p])
    );
  end

  // read mux and registered read port
  always_comb begin
    rd_mux = '0;
    case (host_addr)
      ADR_MASK: rd_mux[NUM_LAYERS-1:0] = mask_q;
      ADR_CFG: begin
        rd_mux[CNT_W-1:0]               = thr_q;
        rd_mux[CFG_WIN_LSB +: WIN_W]    = winm1_q;
      end
      ADR_STAT:    rd_mux[0] = attn_q;
      ADR_CAP: begin
        rd_mux[NUM_LAYERS-1:0]            = cap_raw_q;
        rd_mux[CAP_FLAG_LSB +: NUM_PRESETS] = cap_flag_q;
      end
      ADR_TRIGCNT: rd_mux[TRIG_SCALER_W-1:0] = trig_cnt;
      default: begin
        for (int i = 0; i < NUM_PRESETS; i++)
          if (host_addr == ADR_PRESET0 + 4'(i))
            rd_mux[PRESET_SCALER_W-1:0] = preset_cnt[i];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata = rdata_q;
  assign trig_out   = trig_q;
  assign host_attn  = attn_q;

  // R6
  attn_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (attn_q && !clr_attn) |=> attn_q);

  // R7
  trig_veto_chk: assert property (@(posedge clk) disable iff (rst)
    trig_q |-> !$past(attn_q));

  // R7
  trig_single_chk: assert property (@(posedge clk) disable iff (rst)
    trig_q |=> !trig_q);

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    attn_q |=> ($stable(cap_raw_q) && $stable(cap_flag_q)));

  // R4
  thr_range_chk: assert property (@(posedge clk) disable iff (rst)
    (thr_q != '0) && (thr_q <= CNT_W'(NUM_LAYERS)));
endmodule

// File: tb/layer_coinc_trigger_tb.sv
module layer_coinc_trigger_tb;
  localparam int PSW = 4;
  localparam int TSW = 5;
  localparam int PMAX = (1 << PSW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] layer_in = '0;
  logic [3:0]  host_addr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic        trig_out, host_attn;

  int n_chk = 0;
  int n_bad = 0;
  int exp_pre [4];
  int exp_trig = 0;
  int pn [4] = '{1, 2, 4, 8};
  bit done = 1'b0;

  always #4 clk = ~clk;

  layer_coinc_trigger #(.PRESET_SCALER_W(PSW), .TRIG_SCALER_W(TSW)) u_dut (
    .clk(clk), .rst(rst), .layer_in(layer_in), .host_addr(host_addr),
    .host_we(host_we), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .trig_out(trig_out), .host_attn(host_attn)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic account(input int live);
    for (int i = 0; i < 4; i++)
      if (live >= pn[i] && exp_pre[i] < PMAX) exp_pre[i]++;
  endtask

  // drive p0 for hold0 cycles, p1 for one cycle at offset gap; watch trig_out
  task automatic run(input logic [11:0] p0, input int hold0, input int gap,
                     input logic [11:0] p1, output int first, output int hits);
    first = -1; hits = 0;
    @(negedge clk);
    layer_in = p0;
    for (int i = 1; i <= 16; i++) begin
      @(negedge clk);
      if (trig_out) begin
        hits++;
        if (first < 0) first = i;
      end
      layer_in = ((i < hold0) ? p0 : 12'h000) | ((gap > 0 && i == gap) ? p1 : 12'h000);
    end
  endtask

  task automatic check_scalers(input string req);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(4'(8 + i), d);
      chk(req, $sformatf("preset scaler %0d", i), d, 32'(exp_pre[i]));
    end
    rd(4'd5, d);
    chk("R10", "trigger scaler", d, 32'(exp_trig));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R12", "trig_out after reset", 32'(trig_out), 0);
    chk("R12", "attention after reset", 32'(host_attn), 0);
    rd(4'd0, d); chk("R12", "MASK reset", d, 0);
    rd(4'd1, d); chk("R13", "CFG reset readback", d, 32'h2);
    rd(4'd3, d); chk("R12", "STAT reset", d, 0);
    rd(4'd4, d); chk("R12", "CAP reset", d, 0);
    check_scalers("R12");
  endtask

  task automatic t_threshold;
    int f, h;
    run(12'h003, 1, 0, 0, f, h);
    chk("R3", "2 of n=2 first pulse cycle", 32'(f), 4);
    chk("R3", "2 of n=2 pulse count", 32'(h), 1);
    chk("R6", "attention after trigger", 32'(host_attn), 1);
    account(2); exp_trig++;
    wr(4'd2, 32'h1);
    chk("R6", "attention cleared", 32'(host_attn), 0);
    run(12'h001, 1, 0, 0, f, h);
    chk("R3", "1 of n=2 no pulse", 32'(h), 0);
    account(1);
    wr(4'd1, 32'h3);
    run(12'h007, 1, 0, 0, f, h);
    chk("R3", "3 of n=3 pulse", 32'(h), 1);
    account(3); exp_trig++;
    wr(4'd2, 32'h1);
    run(12'h003, 1, 0, 0, f, h);
    chk("R3", "2 of n=3 no pulse", 32'(h), 0);
    account(2);
  endtask

  task automatic t_clamp;
    logic [31:0] d;
    int f, h;
    wr(4'd1, 32'h0); rd(4'd1, d); chk("R4", "n=0 stored as 1", d, 32'h1);
    wr(4'd1, 32'hF); rd(4'd1, d); chk("R4", "n=15 stored as 12", d, 32'hC);
    run(12'hFFF, 1, 0, 0, f, h);
    chk("R4", "12 layers at n=12 pulse", 32'(h), 1);
    account(12); exp_trig++;
    wr(4'd2, 32'h1);
    run(12'h7FF, 1, 0, 0, f, h);
    chk("R4", "11 layers at n=12 no pulse", 32'(h), 0);
    account(11);
  endtask

  task automatic t_held;
    int f, h;
    wr(4'd1, 32'h2);
    run(12'h003, 9, 0, 0, f, h);
    chk("R1", "held level first pulse", 32'(f), 4);
    chk("R1", "held level single pulse", 32'(h), 1);
    account(2); exp_trig++;
    wr(4'd2, 32'h1);
    check_scalers("R1");
  endtask

  task automatic t_window;
    int f, h;
    wr(4'd1, 32'h202);
    run(12'h001, 1, 2, 12'h002, f, h);
    chk("R2", "spacing W-1 groups, pulse cycle", 32'(f), 6);
    chk("R2", "spacing W-1 groups, pulse count", 32'(h), 1);
    account(2); exp_trig++;
    wr(4'd2, 32'h1);
    run(12'h001, 1, 3, 12'h002, f, h);
    chk("R2", "spacing W splits", 32'(h), 0);
    account(1); account(1);
    check_scalers("R2");
    wr(4'd1, 32'h2);
  endtask

  task automatic t_mask_capture;
    logic [31:0] d;
    int f, h;
    wr(4'd0, 32'h002);
    run(12'h003, 1, 0, 0, f, h);
    chk("R5", "masked layer not counted", 32'(h), 0);
    account(1);
    run(12'h007, 1, 0, 0, f, h);
    chk("R5", "two unmasked of three fire", 32'(h), 1);
    account(2); exp_trig++;
    rd(4'd4, d);
    chk("R8", "CAP raw pattern and flags", d, 32'h0003_0007);
  endtask

  task automatic t_veto;
    logic [31:0] d;
    int f, h;
    rd(4'd3, d); chk("R6", "STAT attention set", d, 1);
    run(12'h0F0, 1, 0, 0, f, h);
    chk("R7", "vetoed trigger output", 32'(h), 0);
    account(4);
    rd(4'd4, d); chk("R8", "CAP frozen under attention", d, 32'h0003_0007);
    check_scalers("R9");
    wr(4'd2, 32'h0);
    chk("R6", "CMD bit0 clear keeps attention", 32'(host_attn), 1);
    wr(4'd2, 32'h1);
    rd(4'd3, d); chk("R6", "STAT cleared by CMD", d, 0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_saturate;
    logic [31:0] d;
    int f, h;
    wr(4'd2, 32'h2);
    for (int i = 0; i < 4; i++) exp_pre[i] = 0;
    exp_trig = 0;
    check_scalers("R11");
    wr(4'd1, 32'hC);
    for (int k = 0; k < PMAX + 2; k++) begin
      run(12'h001, 1, 0, 0, f, h);
      account(1);
    end
    rd(4'd8, d); chk("R11", "preset scaler saturates", d, 32'(PMAX));
    check_scalers("R11");
    wr(4'd2, 32'h2);
    rd(4'd8, d); chk("R11", "scaler cleared after saturation", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_pre[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_clamp();
    t_held();
    t_window();
    t_mask_capture();
    t_veto();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule